// File: doc/BRIEF.md
# Slot-Index Pulse Encoder with Serial Output

The block measures how many clock slots pass between a start strobe, raised by the trigger of a pulse source, and a stop strobe, raised by the detector that sees the pulse. Each clock period is one slot and sets the time resolution. A window of 2^CODE_W slots forms one frame, and CODE_W is 4 by default. The slot index in which the stop arrives is the payload of the frame. The block does not report it as a time. It loads the index into a shift register and sends it out one bit per clock. A pulse source that fires at a low rate can therefore deliver CODE_W bits per pulse.

The captured index is also held on a parallel output until the next good frame replaces it. If no stop arrives inside the window, the block raises an overflow pulse and sends no word. Strobes that do not fit the frame sequence are dropped. The exception is a start that arrives while a word is still being shifted out: the block holds that start and begins its frame as soon as the word is complete.

Top module: `ppm_slot_encoder`

## Requirements
- R1: While reset is high, and in the cycle after it, `ser_valid_o`, `ser_bit_o` and `ovf_o` are 0 and `code_o` is 0.
- R2: A stop sampled k rising edges after the edge that sampled the start (1 ≤ k ≤ 16) produces the code k-1. That code appears on `code_o` from the cycle after the stop edge.
- R3: If no stop is sampled within 16 edges after the start edge, `ovf_o` is 1 for exactly the one cycle after the 16th edge. No serial word is sent, and `code_o` keeps its previous value.
- R4: Each captured code leaves on `ser_bit_o` most significant bit first, one bit per cycle, starting in the cycle after the stop edge. `ser_valid_o` is 1 for exactly CODE_W consecutive cycles.
- R5: A stop sampled while no frame is open has no effect on any output.
- R6: After the first stop of a frame is captured, further stops have no effect until a new frame starts. `code_o` changes only in a cycle where a serial word begins.
- R7: A start sampled while a frame is measuring is ignored, and the slot count continues from the first start.
- R8: A start sampled while a word is still being shifted is held. Its frame begins at the edge that ends the last serial bit, and the slot count runs from that edge as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock; one period is one slot |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe from the pulse-source trigger |
| stop_i | input | 1 | Stop strobe from the detector |
| ser_bit_o | output | 1 | Serial data bit, most significant bit first |
| ser_valid_o | output | 1 | High while `ser_bit_o` carries a word bit |
| code_o | output | CODE_W | Last captured slot index |
| ovf_o | output | 1 | One-cycle pulse when a frame ends without a stop |

## Verification
The assertions take the start and stop strobes to be synchronous to `clk`. They also rely on the frame rule that two serial words are always separated by at least one idle cycle, because a new frame can begin no earlier than the final bit edge of the previous word. The stimulus changes the strobes only on falling clock edges. It drives them mostly as one-cycle pulses and holds stop for two cycles only when it tests a repeated stop. The stimulus places starts during measuring, during shifting and after an overflow, so that each case in the frame sequence is reached.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    localparam int unsigned CODE_W_DEF = 4;

    typedef enum logic {
        FS_IDLE    = 1'b0,
        FS_MEASURE = 1'b1
    } frame_state_e;

    typedef struct packed {
        logic begin_frame;
        logic capture;
        logic overflow;
    } frame_evt_t;

    function automatic int unsigned left_width(int unsigned bits);
        return $clog2(bits + 1);
    endfunction

endpackage

// File: rtl/ppm_frame_ctrl.sv
module ppm_frame_ctrl (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                cnt_at_max_i,
    input  logic                ser_free_i,
    output ppm_pkg::frame_evt_t evt_o,
    output logic                measuring_o
);
    import ppm_pkg::*;

    frame_state_e state_q;
    logic         pend_q;

    always_comb begin
        evt_o = '0;
        unique case (state_q)
            FS_IDLE: begin
                evt_o.begin_frame = (start_i || pend_q) && ser_free_i;
            end
            FS_MEASURE: begin
                evt_o.capture  = stop_i;
                evt_o.overflow = !stop_i && cnt_at_max_i;
            end
            default: evt_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            pend_q  <= 1'b0;
        end else begin
            if (evt_o.begin_frame) begin
                state_q <= FS_MEASURE;
                pend_q  <= 1'b0;
            end else if (evt_o.capture || evt_o.overflow) begin
                state_q <= FS_IDLE;
            end else if (state_q == FS_IDLE && start_i && !ser_free_i) begin
                pend_q  <= 1'b1;
            end
        end
    end

    assign measuring_o = (state_q == FS_MEASURE);

endmodule

// File: rtl/ppm_slot_counter.sv
module ppm_slot_counter #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         at_max_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o    = cnt_q;
    assign at_max_o = &cnt_q;

endmodule

// File: rtl/ppm_piso.sv
module ppm_piso #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    output logic         ser_bit_o,
    output logic         ser_valid_o,
    output logic         free_o
);
    localparam int unsigned LEFT_W = ppm_pkg::left_width(W);

    logic [W-1:0]      shreg_q;
    logic [LEFT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            left_q  <= '0;
        end else if (load_i) begin
            shreg_q <= din_i;
            left_q  <= LEFT_W'(W);
        end else if (left_q != '0) begin
            shreg_q <= {shreg_q[W-2:0], 1'b0};
            left_q  <= left_q - 1'b1;
        end
    end

    assign ser_bit_o   = shreg_q[W-1];
    assign ser_valid_o = (left_q != '0);
    assign free_o      = (left_q <= LEFT_W'(1));

endmodule

// File: rtl/ppm_slot_encoder.sv
module ppm_slot_encoder #(
    parameter int unsigned CODE_W = ppm_pkg::CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              ser_bit_o,
    output logic              ser_valid_o,
    output logic [CODE_W-1:0] code_o,
    output logic              ovf_o
);
    import ppm_pkg::*;

    frame_evt_t        evt;
    logic              measuring;
    logic              at_max;
    logic              ser_free;
    logic [CODE_W-1:0] slot_cnt;
    logic [CODE_W-1:0] code_q;
    logic              ovf_q;

    ppm_frame_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .cnt_at_max_i (at_max),
        .ser_free_i   (ser_free),
        .evt_o        (evt),
        .measuring_o  (measuring)
    );

    ppm_slot_counter #(.W(CODE_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (evt.begin_frame),
        .inc_i    (measuring && !evt.capture && !evt.overflow),
        .cnt_o    (slot_cnt),
        .at_max_o (at_max)
    );

    ppm_piso #(.W(CODE_W)) u_piso (
        .clk         (clk),
        .rst         (rst),
        .load_i      (evt.capture),
        .din_i       (slot_cnt),
        .ser_bit_o   (ser_bit_o),
        .ser_valid_o (ser_valid_o),
        .free_o      (ser_free)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            ovf_q <= evt.overflow;
            if (evt.capture) begin
                code_q <= slot_cnt;
            end
        end
    end

    assign code_o = code_q;
    assign ovf_o  = ovf_q;

endmodule

// File: rtl/ppm_slot_encoder_chk.sv
module ppm_slot_encoder_chk #(
    parameter int unsigned CODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ser_bit_o,
    input logic              ser_valid_o,
    input logic [CODE_W-1:0] code_o,
    input logic              ovf_o
);
    localparam int unsigned RUN_W = $clog2(CODE_W + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (ser_valid_o) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!ser_valid_o && !ovf_o && code_o == '0));

    assert_ovf_no_word_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> !ser_valid_o);

    assert_ovf_single_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> !ovf_o);

    assert_word_len_R4: assert property (@(posedge clk) disable iff (rst)
        (!ser_valid_o && run_q != '0) |-> (run_q == RUN_W'(CODE_W)));

    assert_word_not_long_R4: assert property (@(posedge clk) disable iff (rst)
        ser_valid_o |-> (run_q < RUN_W'(CODE_W)));

    assert_msb_first_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_valid_o) |-> (ser_bit_o == code_o[CODE_W-1]));

    assert_code_held_R6: assert property (@(posedge clk) disable iff (rst)
        !$rose(ser_valid_o) |-> $stable(code_o));

endmodule

bind ppm_slot_encoder ppm_slot_encoder_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ser_bit_o   (ser_bit_o),
    .ser_valid_o (ser_valid_o),
    .code_o      (code_o),
    .ovf_o       (ovf_o)
);

// File: tb/test_ppm_slot_encoder.sv
module test_ppm_slot_encoder;

    localparam int CODE_W = 4;
    localparam int NVEC   = 6;
    localparam int VEC_GAP  [NVEC] = '{1, 2, 6, 11, 16, 17};
    localparam int VEC_CODE [NVEC] = '{0, 1, 5, 10, 15, 15};
    localparam bit VEC_OVF  [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    logic              clk = 1'b0;
    logic              rst;
    logic              start_i;
    logic              stop_i;
    logic              ser_bit_o;
    logic              ser_valid_o;
    logic [CODE_W-1:0] code_o;
    logic              ovf_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ppm_slot_encoder #(.CODE_W(CODE_W)) i_ppm_slot_encoder (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .ser_bit_o   (ser_bit_o),
        .ser_valid_o (ser_valid_o),
        .code_o      (code_o),
        .ovf_o       (ovf_o)
    );

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    // Entered in the cycle after the stop edge; leaves one cycle after the word.
    task automatic expect_word(input int code, input string req);
        for (int b = CODE_W - 1; b >= 0; b--) begin
            check({req, " valid"}, int'(ser_valid_o), 1);
            check({req, " bit"}, int'(ser_bit_o), (code >> b) & 1);
            @(negedge clk);
        end
        check({req, " valid end"}, int'(ser_valid_o), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; stop_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", int'(ser_valid_o), 0);
        check("R1 bit", int'(ser_bit_o), 0);
        check("R1 ovf", int'(ovf_o), 0);
        check("R1 code", int'(code_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after", int'(ser_valid_o), 0);

        // Vector table: R2 codes, R4 serial words, R3 overflow
        for (int i = 0; i < NVEC; i++) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            if (!VEC_OVF[i]) begin
                repeat (VEC_GAP[i] - 1) @(negedge clk);
                stop_i = 1'b1;
                @(negedge clk);
                stop_i = 1'b0;
                check("R2 code", int'(code_o), VEC_CODE[i]);
                expect_word(VEC_CODE[i], "R4");
            end else begin
                repeat (16) @(negedge clk);
                check("R3 ovf pulse", int'(ovf_o), 1);
                check("R3 no word", int'(ser_valid_o), 0);
                check("R3 code kept", int'(code_o), VEC_CODE[i]);
                @(negedge clk);
                check("R3 ovf one cycle", int'(ovf_o), 0);
                check("R3 no word later", int'(ser_valid_o), 0);
            end
            repeat (2) @(negedge clk);
        end

        // R5: stop with no frame open
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        for (int c = 0; c < 3; c++) begin
            check("R5 no word", int'(ser_valid_o), 0);
            check("R5 no ovf", int'(ovf_o), 0);
            check("R5 code kept", int'(code_o), 15);
            @(negedge clk);
        end

        // R6: stop held for two samples, code 2 = 0010
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        check("R6 code", int'(code_o), 2);
        check("R6 b3", int'(ser_bit_o), 0);
        check("R6 valid", int'(ser_valid_o), 1);
        @(negedge clk);
        stop_i = 1'b0;
        check("R6 code after second stop", int'(code_o), 2);
        check("R6 b2", int'(ser_bit_o), 0);
        @(negedge clk);
        check("R6 b1", int'(ser_bit_o), 1);
        @(negedge clk);
        check("R6 b0", int'(ser_bit_o), 0);
        check("R6 valid last", int'(ser_valid_o), 1);
        @(negedge clk);
        check("R6 word ended", int'(ser_valid_o), 0);
        repeat (3) @(negedge clk);
        check("R6 no extra word", int'(ser_valid_o), 0);
        check("R6 code stays", int'(code_o), 2);

        // R7: second start during measuring; stop 5 edges after first -> 4
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R7 code", int'(code_o), 4);
        expect_word(4, "R7");
        repeat (2) @(negedge clk);

        // R8: start during shifting is held
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R8 first code", int'(code_o), 1);
        check("R8 first b3", int'(ser_bit_o), 0);
        @(negedge clk);
        start_i = 1'b1;
        check("R8 first b2", int'(ser_bit_o), 0);
        @(negedge clk);
        start_i = 1'b0;
        check("R8 first b1", int'(ser_bit_o), 0);
        @(negedge clk);
        check("R8 first b0", int'(ser_bit_o), 1);
        check("R8 first valid", int'(ser_valid_o), 1);
        @(negedge clk);
        check("R8 gap", int'(ser_valid_o), 0);
        @(negedge clk);
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R8 held frame code", int'(code_o), 2);
        expect_word(2, "R8");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule